// File: doc/BRIEF.md
# Word-Level Parallel-Prefix Wide Adder

This block adds two unsigned operands that can be thousands of bits wide. Both operands are cut into lanes. A lane is a chunk of one or more 32-bit words. Each lane forms its own partial sum with a short internal word-to-word ripple. It then reduces its chunk to a single 32-bit carry status code: all ones when an incoming carry would pass straight through, 1 when the lane itself wraps, and 0 when the lane absorbs any carry.

A Hillis-Steele scan resolves those codes into lane carries in a logarithmic number of levels, using one merge operator. The operator takes the signed maximum of the two codes and ANDs the result with the upper lane's code. The scan is two-level: first inside fixed-size groups of lanes, then across the group leaders, and the group prefix is finally folded back into every lane. Each lane then adds its resolved carry-in to its lowest word and ripples it upward.

Operands are captured on `valid_i`, and the registered sum and carry-out appear with `valid_o` exactly two clock cycles later. A new operation can be issued on every cycle.

Top module: `wide_prefix_adder`

## Requirements
- R1: When `valid_o` is 1, `{carry_o, sum_o}` equals the full (OP_W+1)-bit unsigned sum of the `a_i` and `b_i` presented with `valid_i` two rising edges earlier.
- R2: `valid_o` equals `valid_i` delayed by exactly two rising clock edges.
- R3: Adding 1 to an all-ones operand, in either operand order, carries through every word of every lane and gives `sum_o` = 0 with `carry_o` = 1.
- R4: A lane counts as pass-through only when every word of its chunk sum is all ones. A carry entering a lane whose chunk sum has some all-ones low words but a non-all-ones top word stops inside that lane.
- R5: No carry enters the lowest lane. When every lane sum is all ones (for example `b_i` = ~`a_i`), the result is all ones with `carry_o` = 0.
- R6: A carry created in a lane reaches every lane above it through any run of pass-through lanes and stops at the first lane that neither wraps nor passes. The top lane's resolved carry is `carry_o`.
- R7: While `valid_o` is 0, `sum_o` and `carry_o` keep their last values, whatever is driven on `a_i` and `b_i`.
- R8: While `rst_ni` is low, and after its release until the first valid result, `valid_o`, `sum_o` and `carry_o` are 0.
- R9: A carry crosses group boundaries of the two-level scan. A carry created in the top lane of the lowest group, with pass-through lanes above it, arrives as `carry_o` = 1.
- R10: Operations issued on consecutive cycles yield results on consecutive cycles, in issue order and independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands on a_i/b_i are valid this cycle |
| a_i | input | OP_W | First operand, word 0 in the low bits |
| b_i | input | OP_W | Second operand, word 0 in the low bits |
| valid_o | output | 1 | sum_o/carry_o hold a new result |
| sum_o | output | OP_W | Sum modulo 2^OP_W |
| carry_o | output | 1 | Carry out of the top word |

## Verification
The hardest situations to reach are long runs of pass-through lanes. Uniform random operands almost never make a 128-bit chunk sum all ones, so the scan's deeper levels and the group fold-back would go untested. The stimulus therefore builds operands lane by lane. Each lane is randomly made to pass through (`b` = ~`a`), to wrap (both all ones), to absorb (both zero) or to be random. Directed cases then place the carry source exactly at the group edge, at lane 0, and inside a partially all-ones chunk.

// File: rtl/wadd_pkg.sv
package wadd_pkg;
  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  // carry status codes; pass-through doubles as scan identity
  localparam word_t ST_PASS = '1;
  localparam word_t ST_MAKE = word_t'(1);
  localparam word_t ST_STOP = '0;

  // hi: status of the upper span, lo: status of the span below it
  function automatic word_t carry_merge(word_t hi, word_t lo);
    word_t m;
    m = ($signed(hi) > $signed(lo)) ? hi : lo;
    return m & hi;
  endfunction
endpackage

// File: rtl/wadd_lane_sum.sv
module wadd_lane_sum
  import wadd_pkg::*;
#(
  parameter int unsigned WPL = 4,
  localparam int unsigned LANE_W = WPL * WORD_W
) (
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  output logic [LANE_W-1:0] sum_o,
  output word_t             st_o
);
  logic [WPL:0] cy;
  assign cy[0] = 1'b0;

  for (genvar w = 0; w < WPL; w++) begin : g_word
    assign {cy[w+1], sum_o[w*WORD_W +: WORD_W]} =
        {1'b0, a_i[w*WORD_W +: WORD_W]} + {1'b0, b_i[w*WORD_W +: WORD_W]}
        + {{WORD_W{1'b0}}, cy[w]};
  end

  // wrap and all-ones cannot both hold
  always_comb begin
    if (&sum_o)        st_o = ST_PASS;
    else if (cy[WPL])  st_o = ST_MAKE;
    else               st_o = ST_STOP;
  end
endmodule

// File: rtl/wadd_lane_fix.sv
module wadd_lane_fix
  import wadd_pkg::*;
#(
  parameter int unsigned WPL = 4,
  localparam int unsigned LANE_W = WPL * WORD_W
) (
  input  logic [LANE_W-1:0] sum_i,
  input  logic              cin_i,
  output logic [LANE_W-1:0] sum_o
);
  logic [WPL-1:0] cy;
  assign cy[0] = cin_i;

  for (genvar w = 0; w < WPL; w++) begin : g_word
    assign sum_o[w*WORD_W +: WORD_W] =
        sum_i[w*WORD_W +: WORD_W] + {{(WORD_W-1){1'b0}}, cy[w]};
    if (w < WPL - 1) begin : g_ripple
      assign cy[w+1] = cy[w] & (&sum_i[w*WORD_W +: WORD_W]);
    end
  end
endmodule

// File: rtl/wadd_scan.sv
module wadd_scan
  import wadd_pkg::*;
#(
  parameter int unsigned N = 4,
  localparam int unsigned STAGES = (N > 1) ? $clog2(N) : 0
) (
  input  word_t [N-1:0] st_i,
  output word_t [N-1:0] st_o
);
  word_t [N-1:0] lvl [STAGES+1];
  assign lvl[0] = st_i;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    for (genvar i = 0; i < N; i++) begin : g_node
      if (i >= (1 << k)) begin : g_mix
        assign lvl[k+1][i] = carry_merge(lvl[k][i], lvl[k][i-(1<<k)]);
      end else begin : g_edge
        assign lvl[k+1][i] = carry_merge(lvl[k][i], ST_PASS);
      end
    end
  end

  assign st_o = lvl[STAGES];
endmodule

// File: rtl/wadd_prefix.sv
module wadd_prefix
  import wadd_pkg::*;
#(
  parameter int unsigned LANES = 8,
  parameter int unsigned GROUP = 4,
  localparam int unsigned NGRP = LANES / GROUP
) (
  input  word_t [LANES-1:0] st_i,
  output word_t [LANES-1:0] res_o
);
  word_t [LANES-1:0] local_res;
  word_t [NGRP-1:0]  lead;
  word_t [NGRP-1:0]  lead_res;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    wadd_scan #(.N(GROUP)) u_scan (
      .st_i (st_i[g*GROUP +: GROUP]),
      .st_o (local_res[g*GROUP +: GROUP])
    );
    assign lead[g] = local_res[g*GROUP + GROUP - 1];
  end

  wadd_scan #(.N(NGRP)) u_lead (
    .st_i (lead),
    .st_o (lead_res)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_fold
    if (i / GROUP == 0) begin : g_base
      assign res_o[i] = local_res[i];
    end else begin : g_up
      assign res_o[i] = carry_merge(local_res[i], lead_res[i/GROUP - 1]);
    end
  end
endmodule

// File: rtl/wide_prefix_adder.sv
module wide_prefix_adder
  import wadd_pkg::*;
#(
  parameter int unsigned LANES          = 8,
  parameter int unsigned WORDS_PER_LANE = 4,
  parameter int unsigned GROUP_LANES    = 4,
  localparam int unsigned LANE_W = WORDS_PER_LANE * WORD_W,
  localparam int unsigned OP_W   = LANES * LANE_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [OP_W-1:0] a_i,
  input  logic [OP_W-1:0] b_i,
  output logic            valid_o,
  output logic [OP_W-1:0] sum_o,
  output logic            carry_o
);
  logic            v_q;
  logic [OP_W-1:0] a_q, b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= 1'b0;
      a_q <= '0;
      b_q <= '0;
    end else begin
      v_q <= valid_i;
      if (valid_i) begin
        a_q <= a_i;
        b_q <= b_i;
      end
    end
  end

  logic [OP_W-1:0]   part_sum, fix_sum;
  word_t [LANES-1:0] lane_st, lane_res;
  logic  [LANES-1:0] lane_cin;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    wadd_lane_sum #(.WPL(WORDS_PER_LANE)) u_sum (
      .a_i   (a_q[l*LANE_W +: LANE_W]),
      .b_i   (b_q[l*LANE_W +: LANE_W]),
      .sum_o (part_sum[l*LANE_W +: LANE_W]),
      .st_o  (lane_st[l])
    );
    if (l == 0) begin : g_low
      assign lane_cin[l] = 1'b0;
    end else begin : g_hi
      // pass-through resolved to the bottom means no carry
      assign lane_cin[l] = (lane_res[l-1] == ST_MAKE);
    end
    wadd_lane_fix #(.WPL(WORDS_PER_LANE)) u_fix (
      .sum_i (part_sum[l*LANE_W +: LANE_W]),
      .cin_i (lane_cin[l]),
      .sum_o (fix_sum[l*LANE_W +: LANE_W])
    );
  end

  wadd_prefix #(.LANES(LANES), .GROUP(GROUP_LANES)) u_prefix (
    .st_i  (lane_st),
    .res_o (lane_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sum_o   <= '0;
      carry_o <= 1'b0;
    end else begin
      valid_o <= v_q;
      if (v_q) begin
        sum_o   <= fix_sum;
        carry_o <= (lane_res[LANES-1] == ST_MAKE);
      end
    end
  end
endmodule

// File: rtl/wadd_checker.sv
module wadd_checker
  import wadd_pkg::*;
#(
  parameter int unsigned LANES = 8,
  parameter int unsigned OP_W  = 1024
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [OP_W-1:0]   a_i,
  input logic [OP_W-1:0]   b_i,
  input logic              v_q,
  input word_t [LANES-1:0] lane_st,
  input word_t [LANES-1:0] lane_res,
  input logic              valid_o,
  input logic [OP_W-1:0]   sum_o,
  input logic              carry_o
);
  logic all_pass;
  always_comb begin
    all_pass = 1'b1;
    for (int i = 0; i < int'(LANES); i++) all_pass &= (lane_st[i] == ST_PASS);
  end

  a_r2_valid_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ##1 valid_o);
  a_r2_valid_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ##1 !valid_o);
  a_r1_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ({carry_o, sum_o} == ($past({1'b0, a_i}, 2) + $past({1'b0, b_i}, 2))));
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(sum_o) && $stable(carry_o)));
  a_r5_all_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q && all_pass) |=> (!carry_o && (&sum_o)));
  a_r6_top_make: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q && lane_st[LANES-1] == ST_MAKE) |=> carry_o);
  a_r6_top_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q && lane_st[LANES-1] == ST_STOP) |=> !carry_o);

  for (genvar i = 0; i < LANES; i++) begin : g_code
    a_r6_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lane_res[i] == ST_PASS || lane_res[i] == ST_MAKE || lane_res[i] == ST_STOP));
  end
endmodule

bind wide_prefix_adder wadd_checker #(.LANES(LANES), .OP_W(OP_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .v_q      (v_q),
  .lane_st  (lane_st),
  .lane_res (lane_res),
  .valid_o  (valid_o),
  .sum_o    (sum_o),
  .carry_o  (carry_o)
);

// File: tb/wide_prefix_adder_bench.sv
module wide_prefix_adder_bench;
  localparam int LANES = 8, WPL = 4, GRP = 4, WW = 32;
  localparam int LANE_W = WPL * WW;
  localparam int OP_W = LANES * LANE_W;

  logic            clk = 1'b0, rst_n = 1'b0, vin = 1'b0;
  logic [OP_W-1:0] a = '0, b = '0;
  logic            vout, cout;
  logic [OP_W-1:0] sum;

  always #10 clk = ~clk;

  wide_prefix_adder #(.LANES(LANES), .WORDS_PER_LANE(WPL), .GROUP_LANES(GRP)) u_wide_prefix_adder (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vin), .a_i(a), .b_i(b),
    .valid_o(vout), .sum_o(sum), .carry_o(cout)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  logic          d1_v = 1'b0, d2_v = 1'b0;
  logic [OP_W:0] d1_e = '0, d2_e = '0, last_e = '0;
  string         d1_t = "", d2_t = "";

  function automatic logic [OP_W:0] model(logic [OP_W-1:0] x, logic [OP_W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  function automatic logic [OP_W-1:0] rnd_op();
    logic [OP_W-1:0] v;
    for (int w = 0; w < OP_W / WW; w++) v[w*WW +: WW] = $urandom;
    return v;
  endfunction

  task automatic check_res(string tag, logic [OP_W:0] act, logic [OP_W:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_bit(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // one negedge: check what was issued two edges ago, then drive new inputs
  task automatic step(bit v, logic [OP_W-1:0] x, logic [OP_W-1:0] y, string tag);
    @(negedge clk);
    check_bit("R2 valid latency", vout, d2_v);
    if (d2_v) begin
      check_res(d2_t, {cout, sum}, d2_e);
      last_e = d2_e;
    end else begin
      check_res("R7 hold while idle", {cout, sum}, last_e);
    end
    d2_v = d1_v; d2_e = d1_e; d2_t = d1_t;
    d1_v = v; d1_e = model(x, y); d1_t = tag;
    vin = v; a = x; b = y;
  endtask

  // lanes randomly set to pass, make, stop or random
  task automatic mixed_pair(output logic [OP_W-1:0] x, output logic [OP_W-1:0] y);
    x = rnd_op(); y = rnd_op();
    for (int l = 0; l < LANES; l++) begin
      case ($urandom % 4)
        0: y[l*LANE_W +: LANE_W] = ~x[l*LANE_W +: LANE_W];
        1: begin x[l*LANE_W +: LANE_W] = '1; y[l*LANE_W +: LANE_W] = '1; end
        2: begin x[l*LANE_W +: LANE_W] = '0; y[l*LANE_W +: LANE_W] = '0; end
        default: ;
      endcase
    end
  endtask

  initial begin
    #(20 * 50000);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [OP_W-1:0] x, y;
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    // R8: reset state
    check_bit("R8 reset valid_o", vout, 1'b0);
    check_res("R8 reset result", {cout, sum}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, rnd_op(), rnd_op(), "R7");
    check_res("R8 after release", {cout, sum}, '0);

    // R3: all ones plus one, both orders
    x = '1; y = '0; y[0] = 1'b1;
    step(1'b1, x, y, "R3 ones+1");
    step(1'b1, y, x, "R3 1+ones");
    // R5: every lane passes, no carry enters at the bottom
    x = rnd_op();
    step(1'b1, x, ~x, "R5 all pass");
    // R6: lane0 makes, lanes 1..2 pass, lane3 stops
    x = rnd_op(); y = rnd_op();
    x[0 +: LANE_W] = '1; y[0 +: LANE_W] = '1;
    for (int l = 1; l < 3; l++) y[l*LANE_W +: LANE_W] = ~x[l*LANE_W +: LANE_W];
    x[3*LANE_W +: LANE_W] = '0; y[3*LANE_W +: LANE_W] = '0;
    step(1'b1, x, y, "R6 stop at kill");
    // R6: lane0 makes, every other lane passes
    x = rnd_op(); y = ~x;
    x[0 +: LANE_W] = '1; y[0 +: LANE_W] = '1;
    step(1'b1, x, y, "R6 carry to top");
    // R9: carry made at top lane of group 0, passes through group 1
    x = rnd_op(); y = ~x;
    x[0 +: 3*LANE_W] = '0; y[0 +: 3*LANE_W] = '0;
    x[3*LANE_W +: LANE_W] = '1; y[3*LANE_W +: LANE_W] = '1;
    step(1'b1, x, y, "R9 cross group");
    // R4: lane1 low words all ones, top word not
    x = rnd_op(); y = rnd_op();
    x[0 +: LANE_W] = '1; y[0 +: LANE_W] = '1;
    y[LANE_W +: 3*WW] = ~x[LANE_W +: 3*WW];
    x[LANE_W + 3*WW +: WW] = '0; y[LANE_W + 3*WW +: WW] = 32'd5;
    step(1'b1, x, y, "R4 partial pass");
    // R7: idle with junk on the operands
    repeat (4) step(1'b0, rnd_op(), rnd_op(), "R7");

    // R10/R1: back-to-back mixed and random traffic with gaps
    for (int n = 0; n < 400; n++) begin
      if ($urandom % 2) mixed_pair(x, y);
      else begin x = rnd_op(); y = rnd_op(); end
      step(($urandom % 5) != 0, x, y, (n % 2) ? "R10 stream" : "R1 sum");
    end
    repeat (3) step(1'b0, '0, '0, "R7");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule